// File: doc/BRIEF.md
# SPI Control and Status Register Unit

This block is the register-side control logic of an SPI peripheral that can act as master or slave. A simple memory-mapped bus writes the control, transmit-data, interrupt-enable and interrupt-disable locations. It reads the status, receive-data and interrupt-mask locations. Reads return combinational data in the same cycle as the read strobe. Any side effect of a read takes place at the clock edge that ends that cycle.

On the other side sits the serializer, which is outside this block. It reports its events as single-cycle pulses:
- a word was taken from the transmit holding register;
- a word was received, with its data;
- a mode fault occurred.

It also reports a level that stays high while a transfer is in progress. The unit keeps the enabled state and carries out the disable and software-reset commands. It runs the transmit-empty and receive-full handshakes, holds the sticky overrun and mode-fault flags, and drives one interrupt line gated by a mask.

Word addresses: 0 control (write), 1 transmit data (write), 2 status (read), 3 receive data (read), 4 interrupt-mask set (write), 5 interrupt-mask clear (write), 6 interrupt mask (read). Other addresses read zero.

Top module: `spi_regblock`

## Requirements
- R1: After reset, the status, receive-data and mask reads return 0, the irq output is 0 and tx_pending is 0.
- R2: A control write with bit 0 set and bit 1 clear enables the unit: status bit 16 becomes 1, and transmit-empty (status bit 1) becomes 1 if the unit was disabled. A control write with bits 0, 1 and 7 all clear changes nothing.
- R3: A control write with bits 0 and 1 both set leaves the unit disabled.
- R4: A disable request (control bit 1) made while ser_busy is high keeps the unit enabled until the first cycle with ser_busy low, and the unit becomes disabled at that edge. A later enable-only write cancels the pending request.
- R5: A control write with bit 7 set returns every register, flag and the mask to the reset state at the next edge.
- R6: Transmit-empty is 0 whenever the unit is disabled. A transmit-data write clears it and presents bits 15:0 on tx_word. A ser_load pulse while tx_pending is high sets it again. tx_pending equals enabled AND NOT transmit-empty.
- R7: A ser_rx_valid pulse while the unit is enabled stores ser_rx_data and sets receive-full (status bit 0). Receive data reads back in bits 15:0 with bits 31:16 at zero. A receive-data read clears receive-full unless a new word arrives in the same cycle.
- R8: A receive load while receive-full is set, with no receive-data read in that cycle, sets overrun (status bit 3). A status read clears overrun, except that an overrun event in the same cycle leaves it set.
- R9: A ser_mode_fault pulse while the unit is enabled sets mode-fault (status bit 2). The flag stays set until a status read that has no new fault in the same cycle.
- R10: irq is the OR of status bits 3:0 ANDed with the 4-bit mask. A write to address 4 sets the mask bits given by wdata[3:0], and a write to address 5 clears them. Address 6 reads the mask in bits 3:0.
- R11: While the unit is disabled, ser_rx_valid, ser_mode_fault and ser_load have no effect on any flag or on the receive data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ser_busy | input | 1 | Serializer transfer in progress |
| ser_load | input | 1 | Serializer took the transmit word |
| ser_rx_valid | input | 1 | Serializer delivers a received word |
| ser_rx_data | input | 16 | Received word |
| ser_mode_fault | input | 1 | Mode fault event |
| tx_word | output | 16 | Word waiting for the serializer |
| tx_pending | output | 1 | Transmit word available |
| spi_enabled | output | 1 | Current enabled state |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest cases to reach from the ports involve two things happening in the same cycle. One is a status read or receive-data read in the cycle a new receive word or fault arrives. The other is a disable request while ser_busy is held high over several cycles. Random stimulus seldom lines these up with the right state beforehand. Directed sequences therefore set up a full receive register and then issue the read together with the event pulse. They also hold ser_busy across a disable write and drop it later. A seeded random phase then mixes every bus operation with serializer pulses and checks each read, irq and tx_pending every cycle against a bench model.

// File: rtl/spi_reg_pkg.sv
// Package: shared address map and status bit positions of the SPI register unit.
// Assumes word addressing on a narrow bus; positions that software decodes are fixed here.
package spi_reg_pkg;
    localparam int OFS_CTRL   = 0;
    localparam int OFS_TXDATA = 1;
    localparam int OFS_STATUS = 2;
    localparam int OFS_RXDATA = 3;
    localparam int OFS_IRQ_ON = 4;
    localparam int OFS_IRQ_OFF= 5;
    localparam int OFS_MASK   = 6;

    localparam int CTL_ENABLE  = 0;
    localparam int CTL_DISABLE = 1;
    localparam int CTL_SWRST   = 7;

    localparam int ST_RXFULL  = 0;
    localparam int ST_TXEMPTY = 1;
    localparam int ST_MODEF   = 2;
    localparam int ST_OVERRUN = 3;
    localparam int ST_ENABLED = 16;

    localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/spi_en_ctrl.sv
// Module: enable state machine. Tracks the enabled state and a deferred disable
// request that waits for the serializer to go idle. Assumes soft_clr is a one-cycle pulse.
module spi_en_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic ctl_wr,
    input  logic en_bit,
    input  logic dis_bit,
    input  logic ser_busy,
    output logic en_q,
    output logic en_d,
    output logic en_rise
);
    logic pend_q, pend_d;

    // Next enable/pending state; disable wins over enable in one write.
    always_comb begin
        en_d   = en_q;
        pend_d = pend_q;
        if (ctl_wr && dis_bit) begin
            if (en_q && ser_busy) begin
                pend_d = 1'b1;
            end else begin
                en_d   = 1'b0;
                pend_d = 1'b0;
            end
        end else if (ctl_wr && en_bit) begin
            en_d   = 1'b1;
            pend_d = 1'b0;
        end else if (pend_q && !ser_busy) begin
            en_d   = 1'b0;
            pend_d = 1'b0;
        end
    end

    assign en_rise = en_d && !en_q;

    // State registers with synchronous and software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
        end
    end

    // R4: while a transfer is active and no reset occurs, enabled cannot drop.
    p_disable_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && ser_busy && !soft_clr) |=> en_q);
    // R3: a write with both command bits set never leaves the unit newly enabled.
    p_dis_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && en_bit && dis_bit && !en_q) |=> !en_q);
endmodule

// File: rtl/spi_data_flags.sv
// Module: transmit/receive data holding registers and status flags.
// Assumes en_q/en_d/en_rise come from the enable controller; serializer events are gated by en_q.
module spi_data_flags #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              en_q,
    input  logic              en_d,
    input  logic              en_rise,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              ser_load,
    input  logic              ser_rx_valid,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic              ser_mode_fault,
    input  logic              rd_status,
    input  logic              rd_rx,
    output logic              txe_q,
    output logic              rxf_q,
    output logic              ovr_q,
    output logic              mf_q,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_word,
    output logic              tx_pending
);
    logic rx_ev, mf_ev, ovr_ev, load_ev;

    assign tx_pending = en_q && !txe_q;
    assign load_ev    = ser_load && tx_pending;
    assign rx_ev      = ser_rx_valid && en_q;
    assign mf_ev      = ser_mode_fault && en_q;
    assign ovr_ev     = rx_ev && rxf_q && !rd_rx;

    // Transmit-empty handshake and holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            txe_q   <= 1'b0;
            tx_word <= '0;
        end else begin
            if (tx_wr) tx_word <= tx_wdata;
            if (!en_d)         txe_q <= 1'b0;
            else if (en_rise)  txe_q <= 1'b1;
            else if (tx_wr)    txe_q <= 1'b0;
            else if (load_ev)  txe_q <= 1'b1;
        end
    end

    // Receive holding register and receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            rxf_q   <= 1'b0;
            rx_word <= '0;
        end else if (rx_ev) begin
            rxf_q   <= 1'b1;
            rx_word <= ser_rx_data;
        end else if (rd_rx) begin
            rxf_q   <= 1'b0;
        end
    end

    // Sticky error flags; a same-cycle event beats the clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ovr_q <= 1'b0;
            mf_q  <= 1'b0;
        end else begin
            if (ovr_ev)         ovr_q <= 1'b1;
            else if (rd_status) ovr_q <= 1'b0;
            if (mf_ev)          mf_q  <= 1'b1;
            else if (rd_status) mf_q  <= 1'b0;
        end
    end

    // R6: transmit-empty is never set while disabled.
    p_txe_off_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !txe_q);
    // R8: overrun can only rise if the receive register was already full.
    p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(rxf_q));
    // R7: a receive-data read without a new word empties the register.
    p_rd_clears_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_ev && !soft_clr) |=> !rxf_q);
    // R9: mode fault holds until a status read.
    p_mf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_q && !rd_status && !soft_clr) |=> mf_q);
    // R11: with the unit disabled, the receive register does not change.
    p_rx_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !soft_clr) |=> $stable(rx_word));
endmodule

// File: rtl/spi_irq_mask.sv
// Module: interrupt mask register with set/clear write ports and the masked OR.
// Assumes set and clear writes never coincide (they have distinct addresses).
module spi_irq_mask #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic            set_wr,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] wbits,
    input  logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] mask_q,
    output logic            irq
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // One mask bit per source.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr)          mask_q[g] <= 1'b0;
            else if (set_wr && wbits[g])     mask_q[g] <= 1'b1;
            else if (clr_wr && wbits[g])     mask_q[g] <= 1'b0;
        end
        assign hit[g] = flags[g] && mask_q[g];
    end

    assign irq = |hit;

    // R10: bits written through the set port are present one cycle later.
    p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !soft_clr) |=> ((mask_q & $past(wbits)) == $past(wbits)));
    // R10: bits written through the clear port are absent one cycle later.
    p_mask_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask_q & $past(wbits)) == '0));
endmodule

// File: rtl/spi_regblock.sv
// Module: top of the SPI control/status register unit. Decodes the bus,
// builds read data and wires the enable controller, flag logic and irq mask.
// Assumes one bus operation per cycle; read data is combinational.
module spi_regblock #(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ser_busy,
    input  logic              ser_load,
    input  logic              ser_rx_valid,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic              ser_mode_fault,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_pending,
    output logic              spi_enabled,
    output logic              irq
);
    import spi_reg_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFS_TXDATA);
    localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(OFS_RXDATA);
    localparam logic [ADDR_W-1:0] A_ION  = ADDR_W'(OFS_IRQ_ON);
    localparam logic [ADDR_W-1:0] A_IOFF = ADDR_W'(OFS_IRQ_OFF);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic ctl_wr, tx_wr, ion_wr, ioff_wr, rd_status, rd_rx, soft_clr;
    logic en_q, en_d, en_rise;
    logic txe_q, rxf_q, ovr_q, mf_q;
    logic [DATA_W-1:0]    rx_word;
    logic [NUM_FLAGS-1:0] flags, mask_q;
    logic unused_wbits;

    assign ctl_wr    = bus_wr && (bus_addr == A_CTRL);
    assign tx_wr     = bus_wr && (bus_addr == A_TX);
    assign ion_wr    = bus_wr && (bus_addr == A_ION);
    assign ioff_wr   = bus_wr && (bus_addr == A_IOFF);
    assign rd_status = bus_rd && (bus_addr == A_ST);
    assign rd_rx     = bus_rd && (bus_addr == A_RX);
    assign soft_clr  = ctl_wr && bus_wdata[CTL_SWRST];
    assign unused_wbits = ^bus_wdata[BUS_W-1:DATA_W];

    spi_en_ctrl u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .ctl_wr   (ctl_wr),
        .en_bit   (bus_wdata[CTL_ENABLE]),
        .dis_bit  (bus_wdata[CTL_DISABLE]),
        .ser_busy (ser_busy),
        .en_q     (en_q),
        .en_d     (en_d),
        .en_rise  (en_rise)
    );

    spi_data_flags #(.DATA_W(DATA_W)) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_clr       (soft_clr),
        .en_q           (en_q),
        .en_d           (en_d),
        .en_rise        (en_rise),
        .tx_wr          (tx_wr),
        .tx_wdata       (bus_wdata[DATA_W-1:0]),
        .ser_load       (ser_load),
        .ser_rx_valid   (ser_rx_valid),
        .ser_rx_data    (ser_rx_data),
        .ser_mode_fault (ser_mode_fault),
        .rd_status      (rd_status),
        .rd_rx          (rd_rx),
        .txe_q          (txe_q),
        .rxf_q          (rxf_q),
        .ovr_q          (ovr_q),
        .mf_q           (mf_q),
        .tx_word        (tx_word),
        .rx_word        (rx_word),
        .tx_pending     (tx_pending)
    );

    assign flags = {ovr_q, mf_q, txe_q, rxf_q};

    spi_irq_mask #(.NSRC(NUM_FLAGS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .set_wr   (ion_wr),
        .clr_wr   (ioff_wr),
        .wbits    (bus_wdata[NUM_FLAGS-1:0]),
        .flags    (flags),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    assign spi_enabled = en_q;

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_ST: begin
                    bus_rdata[ST_RXFULL]  = rxf_q;
                    bus_rdata[ST_TXEMPTY] = txe_q;
                    bus_rdata[ST_MODEF]   = mf_q;
                    bus_rdata[ST_OVERRUN] = ovr_q;
                    bus_rdata[ST_ENABLED] = en_q;
                end
                A_RX:    bus_rdata[DATA_W-1:0]    = rx_word;
                A_MASK:  bus_rdata[NUM_FLAGS-1:0] = mask_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R5: software reset leaves the unit disabled and the mask empty.
    p_swrst_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!spi_enabled && !irq && !tx_pending));
    // R6: the transmit word follows a transmit write.
    p_txword_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !soft_clr) |=> (tx_word == $past(bus_wdata[DATA_W-1:0])));
endmodule

// File: tb/spi_regblock_bench.sv
`timescale 1ns/1ps
module spi_regblock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        ser_busy = 0, ser_load = 0, ser_rx_valid = 0, ser_mode_fault = 0;
    logic [15:0] ser_rx_data = 0;
    logic [15:0] tx_word;
    logic        tx_pending, spi_enabled, irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    bit m_en, m_pend, m_txe, m_rxf, m_ovr, m_mf;
    bit [15:0] m_rxd, m_txd;
    bit [3:0]  m_mask;

    always #2.5 clk = ~clk;

    spi_regblock u_spi_regblock (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_busy(ser_busy), .ser_load(ser_load), .ser_rx_valid(ser_rx_valid),
        .ser_rx_data(ser_rx_data), .ser_mode_fault(ser_mode_fault),
        .tx_word(tx_word), .tx_pending(tx_pending), .spi_enabled(spi_enabled), .irq(irq)
    );

    function automatic bit [31:0] exp_read(input bit [2:0] a);
        case (a)
            3'd2: return {15'd0, m_en, 12'd0, m_ovr, m_mf, m_txe, m_rxf};
            3'd3: return {16'd0, m_rxd};
            3'd6: return {28'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit exp_irq();
        return |({m_ovr, m_mf, m_txe, m_rxf} & m_mask);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_pend = 0; m_txe = 0; m_rxf = 0; m_ovr = 0; m_mf = 0;
        m_rxd = 0; m_txd = 0; m_mask = 0;
    endtask

    // Model update for one edge, from the requirements, using the held inputs.
    task automatic model_step();
        bit ctl, en_n, rx_ev, ld;
        ctl = bus_wr && bus_addr == 3'd0;
        if (ctl && bus_wdata[7]) begin model_reset(); return; end
        en_n = m_en;
        if (ctl && bus_wdata[1]) begin
            if (m_en && ser_busy) m_pend = 1; else begin en_n = 0; m_pend = 0; end
        end else if (ctl && bus_wdata[0]) begin
            en_n = 1; m_pend = 0;
        end else if (m_pend && !ser_busy) begin
            en_n = 0; m_pend = 0;
        end
        ld = ser_load && m_en && !m_txe;
        if (bus_wr && bus_addr == 3'd1) m_txd = bus_wdata[15:0];
        if (!en_n) m_txe = 0;
        else if (!m_en) m_txe = 1;
        else if (bus_wr && bus_addr == 3'd1) m_txe = 0;
        else if (ld) m_txe = 1;
        rx_ev = ser_rx_valid && m_en;
        if (rx_ev && m_rxf && !(bus_rd && bus_addr == 3'd3)) m_ovr = 1;
        else if (bus_rd && bus_addr == 3'd2) m_ovr = 0;
        if (ser_mode_fault && m_en) m_mf = 1;
        else if (bus_rd && bus_addr == 3'd2) m_mf = 0;
        if (rx_ev) begin m_rxf = 1; m_rxd = ser_rx_data; end
        else if (bus_rd && bus_addr == 3'd3) m_rxf = 0;
        if (bus_wr && bus_addr == 3'd4) m_mask = m_mask | bus_wdata[3:0];
        if (bus_wr && bus_addr == 3'd5) m_mask = m_mask & ~bus_wdata[3:0];
        m_en = en_n;
    endtask

    // One cycle: drive at negedge, check before the edge, update model at the edge.
    task automatic cyc(input string req, input bit wr, input bit rd, input bit [2:0] a,
                       input bit [31:0] wd, input bit busy = 0, input bit ld = 0,
                       input bit rxv = 0, input bit [15:0] rxd = 0, input bit mf = 0);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        ser_busy = busy; ser_load = ld; ser_rx_valid = rxv; ser_rx_data = rxd; ser_mode_fault = mf;
        #1;
        if (rd) chk(req, bus_rdata, exp_read(a));
        chk({req, "/R10 irq"}, {31'd0, irq}, {31'd0, exp_irq()});
        chk({req, "/R6 pending"}, {31'd0, tx_pending}, {31'd0, m_en && !m_txe});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc("idle", 0, 0, 0, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cyc("R1 status", 0, 1, 2, 0);
        chk("R1 literal", bus_rdata, 32'h0);
        cyc("R1 mask", 0, 1, 6, 0);
        cyc("R1 rx", 0, 1, 3, 0);
        // R11 events ignored while disabled
        cyc("R11 rx", 0, 0, 0, 0, 0, 1, 1, 16'h5555, 1);
        cyc("R11 status", 0, 1, 2, 0);
        cyc("R11 rxdata", 0, 1, 3, 0);
        // R2 enable and no-op write
        cyc("R2 en", 1, 0, 0, 32'h1);
        cyc("R2 status", 0, 1, 2, 0);
        chk("R2 literal", bus_rdata, 32'h0001_0002);
        cyc("R2 noop", 1, 0, 0, 32'h0);
        cyc("R2 status2", 0, 1, 2, 0);
        // R6 transmit handshake
        cyc("R6 txw", 1, 0, 1, 32'hFFFF_ABCD);
        chk("R6 word", {16'd0, tx_word}, 32'h0000_ABCD);
        cyc("R6 status", 0, 1, 2, 0);
        cyc("R6 load", 0, 0, 0, 0, 0, 1);
        cyc("R6 status2", 0, 1, 2, 0);
        // R7 receive
        cyc("R7 rx", 0, 0, 0, 0, 0, 0, 1, 16'h1234);
        cyc("R7 rxdata", 0, 1, 3, 0);
        cyc("R7 status", 0, 1, 2, 0);
        // R8 overrun, and read+event in same cycle
        cyc("R8 rx1", 0, 0, 0, 0, 0, 0, 1, 16'h1111);
        cyc("R8 rx2", 0, 0, 0, 0, 0, 0, 1, 16'h2222);
        cyc("R8 st", 0, 1, 2, 0, 0, 0, 1, 16'h3333);
        cyc("R8 st kept", 0, 1, 2, 0);
        cyc("R8 st cleared", 0, 1, 2, 0);
        cyc("R7 rd+rx", 0, 1, 3, 0, 0, 0, 1, 16'h4444);
        cyc("R7 still full", 0, 1, 2, 0);
        // R9 mode fault
        cyc("R9 mf", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);
        cyc("R9 st+mf", 0, 1, 2, 0, 0, 0, 0, 0, 1);
        cyc("R9 kept", 0, 1, 2, 0);
        cyc("R9 cleared", 0, 1, 2, 0);
        // R10 mask
        cyc("R10 set", 1, 0, 4, 32'hF);
        cyc("R10 mask", 0, 1, 6, 0);
        cyc("R10 clr", 1, 0, 5, 32'h5);
        cyc("R10 mask2", 0, 1, 6, 0);
        // R4 deferred disable
        cyc("R4 dis", 1, 0, 0, 32'h2, 1);
        cyc("R4 busy", 0, 1, 2, 0, 1);
        chk("R4 still on", {31'd0, spi_enabled}, 32'd1);
        cyc("R4 busy2", 0, 0, 0, 0, 1);
        cyc("R4 idle", 0, 0, 0, 0, 0);
        chk("R4 off", {31'd0, spi_enabled}, 32'd0);
        cyc("R4 status", 0, 1, 2, 0);
        // R3 both bits
        cyc("R3 both", 1, 0, 0, 32'h3);
        chk("R3 off", {31'd0, spi_enabled}, 32'd0);
        cyc("R3 status", 0, 1, 2, 0);
        // R5 soft reset
        cyc("R5 en", 1, 0, 0, 32'h1);
        cyc("R5 rx", 0, 0, 0, 0, 0, 0, 1, 16'h9999);
        cyc("R5 rst", 1, 0, 0, 32'h80);
        cyc("R5 status", 0, 1, 2, 0);
        chk("R5 literal", bus_rdata, 32'h0);
        cyc("R5 mask", 0, 1, 6, 0);
        cyc("R5 rx", 0, 1, 3, 0);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int op; bit [2:0] a; bit [31:0] wd; bit wr, rd;
            op = $urandom_range(0, 9);
            wr = 0; rd = 0; a = 0; wd = $urandom;
            case (op)
                0: begin wr = 1; a = 0;
                       wd = ($urandom_range(0, 30) == 0) ? 32'h80 : {30'd0, 2'($urandom_range(0, 3))}; end
                1: begin wr = 1; a = 1; end
                2: begin wr = 1; a = 4; end
                3: begin wr = 1; a = 5; end
                4, 5: begin rd = 1; a = 2; end
                6: begin rd = 1; a = 3; end
                7: begin rd = 1; a = 3'($urandom_range(0, 7)); end
                default: ;
            endcase
            cyc("rand R2-R11", wr, rd, a, wd, $urandom_range(0, 2) != 0,
                $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                16'($urandom), $urandom_range(0, 15) == 0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule